// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Address-Width Probe

This block drives a three-wire serial EEPROM (select, clock, data toward the device, data from the device) and reads 16-bit words from it. The host gives a one-cycle start pulse together with either a word index or a request to fetch the station address. The block answers with a one-cycle completion pulse and holds the result on its outputs until the next operation.

The block does not know in advance whether the attached device decodes 6 or 8 address bits. On the first operation after reset it runs a probe read of the highest 8-bit location. It then looks at the response bit that a 6-bit device drives low as its dummy zero, and keeps the width it found for all later reads. In station-address mode the block reads three consecutive words from a fixed word offset and packs their bytes low byte first. It also flags the all-zero and all-ones patterns, which mean no usable address is stored.

Every clock phase on the serial side lasts a parameter number of system clock cycles. This lets the serial clock meet the slow timing of such devices from any system clock.

Top module: `seeprom_reader`

## Requirements
- R1: After reset, busy, done, rom_cs, rom_sk, rom_di, addr8, mac_bad, rd_data and mac_out are all zero.
- R2: The first accepted operation after reset starts with a probe read of address 0xFF using 8 address bits. A 6-bit device drives its dummy zero during the 9th clock of that frame; if the sample taken there is 1, addr8 becomes 1 and 8 address bits are used, otherwise 6. The probe runs only once per reset.
- R3: Each read frame raises rom_cs and sends the start bit 1 and opcode bits 1,0. It then sends the address MSB first at the detected width and clocks in 16 data bits MSB first. rom_cs then drops, and rd_data equals the addressed word.
- R4: rom_sk is high only while rom_cs is high. rom_di changes only while rom_sk is low. rom_do is sampled at the end of each high phase.
- R5: Every high and low phase of rom_sk lasts exactly PHASE_CYC system clock cycles.
- R6: With fetch_mac=1 the block reads words 0x0A, 0x0B and 0x0C. mac_out[47:40] is the low byte of word 0x0A, mac_out[39:32] is its high byte, and so on through the high byte of word 0x0C in mac_out[7:0].
- R7: If the 18-bit sum of the three station-address words is 0 or 0x2FFFD, mac_out is all zeros and mac_bad is 1; otherwise mac_bad is 0. A sum that only wraps in 16 bits (such as 0x10000) is valid.
- R8: busy rises in the cycle after an accepted start and stays high until done. A start pulse while busy is ignored and does not change the running operation or its result. rom_cs is high only while busy.
- R9: done is a one-cycle pulse that is high only while busy is low. rd_data keeps its value until the next word read ends. mac_out and mac_bad keep their values until the next station-address fetch ends.
- R10: After the width is detected, reads on a 6-bit device use word_idx[5:0] and reads on an 8-bit device use all of word_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| fetch_mac | input | 1 | 1 = fetch station address, 0 = read the word at word_idx |
| word_idx | input | 8 | Word address for a single-word read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read in word mode |
| mac_out | output | 48 | Packed station address, zeroed when invalid |
| mac_bad | output | 1 | Station address failed the plausibility check |
| addr8 | output | 1 | Detected device width: 1 = 8 address bits, 0 = 6 |
| rom_cs | output | 1 | EEPROM chip select |
| rom_sk | output | 1 | EEPROM serial clock |
| rom_di | output | 1 | Serial data toward the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |

## Verification
The embedded assertions check the electrical rules of the serial side on every cycle: the clock stays under chip select, data toward the device holds still while the clock is high, and each high phase has the configured length. They also check that select is active only during busy, that done is a single pulse outside busy, that the detected width is sticky, and that a rejected address reads as zeros. Other behaviour only shows in bench scenarios run against a behavioural EEPROM model of each width. These are the frame contents (opcode and address), the width decision of the probe, returned data for random addresses, the station-address byte order, the two rejected sums and a wrapping sum, and a start request ignored during a busy read.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   localparam int OPW = 3;
   localparam logic [OPW-1:0] RD_OP = 3'b110;

   typedef enum logic [1:0] {S_IDLE, S_GO, S_WAIT, S_FIN} seq_st_t;
   typedef enum logic [2:0] {E_IDLE, E_CSUP, E_LOW, E_HIGH, E_TAIL} eng_st_t;
endpackage

// File: rtl/seeprom_phase_tick.sv
module seeprom_phase_tick #(
   parameter int PHASE_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic tick
);
   localparam int CW = $clog2(PHASE_CYC + 1);

   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (load) cnt <= CW'(PHASE_CYC - 1);
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);
endmodule

// File: rtl/seeprom_bit_engine.sv
module seeprom_bit_engine
   import seeprom_pkg::*;
#(
   parameter int PHASE_CYC = 500,
   parameter int CMDW      = 11,
   parameter int DATAW     = 16,
   parameter int KEEPW     = 19,
   parameter int CNTW      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CMDW-1:0]  cmd,
   input  logic [CNTW-1:0]  ncmd,
   output logic             fin,
   output logic [DATAW-1:0] rx_word,
   output logic             rx_probe,
   output logic             cs,
   output logic             sk,
   output logic             di,
   input  logic             sdo
);
   generate
      if (KEEPW <= DATAW) begin : g_bad_keep
         $error("KEEPW must exceed DATAW");
      end
      if ((1 << CNTW) <= CMDW + DATAW) begin : g_bad_cnt
         $error("CNTW too narrow for frame length");
      end
   endgenerate

   eng_st_t          st;
   logic [CMDW-1:0]  sh;
   logic [CNTW-1:0]  bit_no;
   logic [CNTW-1:0]  ncmd_q;
   logic [KEEPW-1:0] rx;
   logic             tick;
   logic             load;

   assign load = (st == E_IDLE) ? go : tick;

   seeprom_phase_tick #(.PHASE_CYC(PHASE_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .load(load), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         sh     <= '0;
         bit_no <= '0;
         ncmd_q <= '0;
         rx     <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (st)
            E_IDLE: if (go) begin
               sh     <= cmd;
               ncmd_q <= ncmd;
               bit_no <= '0;
               rx     <= '0;
               st     <= E_CSUP;
            end
            E_CSUP: if (tick) st <= E_LOW;
            E_LOW:  if (tick) st <= E_HIGH;
            E_HIGH: if (tick) begin
               rx <= {rx[KEEPW-2:0], sdo};
               sh <= {sh[CMDW-2:0], 1'b0};
               if (bit_no == ncmd_q + CNTW'(DATAW - 1)) st <= E_TAIL;
               else begin
                  bit_no <= bit_no + 1'b1;
                  st     <= E_LOW;
               end
            end
            E_TAIL: if (tick) begin
               fin <= 1'b1;
               st  <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   assign cs       = (st != E_IDLE);
   assign sk       = (st == E_HIGH);
   assign di       = ((st == E_LOW) || (st == E_HIGH)) && (bit_no < ncmd_q) && sh[CMDW-1];
   assign rx_word  = rx[DATAW-1:0];
   assign rx_probe = rx[KEEPW-1];

   // checker state: length of the current high phase
   logic [31:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_len <= '0;
      else if (sk) hi_len <= hi_len + 1;
      else hi_len <= '0;
   end

   assert_sk_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sk |-> cs);
   assert_di_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sk && $past(sk)) |-> $stable(di));
   assert_high_phase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sk) |-> (hi_len == 32'(PHASE_CYC)));
endmodule

// File: rtl/seeprom_mac_check.sv
module seeprom_mac_check #(
   parameter int DATAW     = 16,
   parameter int MAC_WORDS = 3,
   localparam int MACW     = DATAW * MAC_WORDS
) (
   input  logic [MAC_WORDS-1:0][DATAW-1:0] words,
   output logic [MACW-1:0]                 mac,
   output logic                            bad
);
   localparam int BPW  = DATAW / 8;
   localparam int SUMW = DATAW + $clog2(MAC_WORDS + 1);
   localparam logic [SUMW-1:0] ONES_SUM = SUMW'(MAC_WORDS * ((1 << DATAW) - 1));

   generate
      if (DATAW % 8 != 0) begin : g_bad_width
         $error("DATAW must be a whole number of bytes");
      end
   endgenerate

   logic [MACW-1:0] raw;
   logic [SUMW-1:0] sum;

   generate
      for (genvar w = 0; w < MAC_WORDS; w++) begin : g_word
         for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign raw[MACW-1-8*(w*BPW+b) -: 8] = words[w][8*b +: 8];
         end
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int w = 0; w < MAC_WORDS; w++) sum = sum + SUMW'(words[w]);
   end

   assign bad = (sum == '0) || (sum == ONES_SUM);
   assign mac = bad ? '0 : raw;
endmodule

// File: rtl/seeprom_reader.sv
module seeprom_reader
   import seeprom_pkg::*;
#(
   parameter int PHASE_CYC = 500,
   parameter int DATAW     = 16,
   parameter int MAXAW     = 8,
   parameter int MINAW     = 6,
   parameter int MAC_BASE  = 10,
   parameter int MAC_WORDS = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   fetch_mac,
   input  logic [MAXAW-1:0]       word_idx,
   output logic                   busy,
   output logic                   done,
   output logic [DATAW-1:0]       rd_data,
   output logic [DATAW*MAC_WORDS-1:0] mac_out,
   output logic                   mac_bad,
   output logic                   addr8,
   output logic                   rom_cs,
   output logic                   rom_sk,
   output logic                   rom_di,
   input  logic                   rom_do
);
   localparam int CMDW  = OPW + MAXAW;
   localparam int RESPW = CMDW + DATAW;
   localparam int KEEPW = RESPW - (OPW + MINAW) + 1;
   localparam int CNTW  = $clog2(RESPW + 1);
   localparam int WPW   = (MAC_WORDS > 1) ? $clog2(MAC_WORDS) : 1;
   localparam int MACW  = DATAW * MAC_WORDS;

   generate
      if (MAXAW <= MINAW) begin : g_bad_aw
         $error("MAXAW must exceed MINAW");
      end
      if (MAC_BASE + MAC_WORDS > (1 << MINAW)) begin : g_bad_base
         $error("station address must fit the narrow device");
      end
   endgenerate

   seq_st_t                        st;
   logic                           sized, probing, mode_q;
   logic [MAXAW-1:0]               idx_q;
   logic [WPW-1:0]                 wptr;
   logic [MAC_WORDS-1:0][DATAW-1:0] words;
   logic [MAXAW-1:0]               addr;
   logic                           wide;
   logic [CMDW-1:0]                cmd;
   logic [CNTW-1:0]                ncmd;
   logic                           eng_fin, eng_probe;
   logic [DATAW-1:0]               eng_word;
   logic [MACW-1:0]                chk_mac;
   logic                           chk_bad;

   always_comb begin
      if (probing)     addr = '1;
      else if (mode_q) addr = MAXAW'(MAC_BASE) + MAXAW'(wptr);
      else             addr = idx_q;
      wide = probing || addr8;
      cmd  = wide ? {RD_OP, addr} : {RD_OP, addr[MINAW-1:0], {(MAXAW-MINAW){1'b0}}};
      ncmd = wide ? CNTW'(OPW + MAXAW) : CNTW'(OPW + MINAW);
   end

   seeprom_bit_engine #(
      .PHASE_CYC(PHASE_CYC), .CMDW(CMDW), .DATAW(DATAW), .KEEPW(KEEPW), .CNTW(CNTW)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .go(st == S_GO), .cmd(cmd), .ncmd(ncmd),
      .fin(eng_fin), .rx_word(eng_word), .rx_probe(eng_probe),
      .cs(rom_cs), .sk(rom_sk), .di(rom_di), .sdo(rom_do)
   );

   seeprom_mac_check #(.DATAW(DATAW), .MAC_WORDS(MAC_WORDS)) u_chk (
      .words(words), .mac(chk_mac), .bad(chk_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         sized   <= 1'b0;
         probing <= 1'b0;
         mode_q  <= 1'b0;
         idx_q   <= '0;
         wptr    <= '0;
         words   <= '0;
         addr8   <= 1'b0;
         rd_data <= '0;
         mac_out <= '0;
         mac_bad <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (start) begin
               mode_q  <= fetch_mac;
               idx_q   <= word_idx;
               wptr    <= '0;
               probing <= !sized;
               st      <= S_GO;
            end
            S_GO: st <= S_WAIT;
            S_WAIT: if (eng_fin) begin
               if (probing) begin
                  sized   <= 1'b1;
                  addr8   <= eng_probe;
                  probing <= 1'b0;
                  st      <= S_GO;
               end else if (!mode_q) begin
                  rd_data <= eng_word;
                  st      <= S_FIN;
               end else begin
                  words[wptr] <= eng_word;
                  if (wptr == WPW'(MAC_WORDS - 1)) st <= S_FIN;
                  else begin
                     wptr <= wptr + 1'b1;
                     st   <= S_GO;
                  end
               end
            end
            S_FIN: begin
               if (mode_q) begin
                  mac_out <= chk_mac;
                  mac_bad <= chk_bad;
               end
               done <= 1'b1;
               st   <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st != S_IDLE);

   assert_done_outside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_cs_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs |-> busy);
   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(idx_q) && $stable(mode_q)));
   assert_bad_means_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mac_bad |-> (mac_out == '0));
   assert_width_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sized |=> (sized && $stable(addr8)));
endmodule

// File: tb/seeprom_reader_test.sv
module seeprom_reader_test;
   localparam int PH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        fetch_mac = 1'b0;
   logic [7:0]  word_idx = '0;
   logic        busy, done, mac_bad, addr8, rom_cs, rom_sk, rom_di, rom_do;
   logic [15:0] rd_data;
   logic [47:0] mac_out;

   always #10 clk = ~clk;

   seeprom_reader #(.PHASE_CYC(PH)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fetch_mac(fetch_mac),
      .word_idx(word_idx), .busy(busy), .done(done), .rd_data(rd_data),
      .mac_out(mac_out), .mac_bad(mac_bad), .addr8(addr8),
      .rom_cs(rom_cs), .rom_sk(rom_sk), .rom_di(rom_di), .rom_do(rom_do)
   );

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit finished = 0;

   // ---------------- behavioural EEPROM model ----------------
   logic [15:0] mem [256];
   int          dev_aw = 6;
   int          m_cnt, m_ptr, trans;
   logic [7:0]  m_addr, last_addr;
   logic [2:0]  m_op, last_op;
   logic [15:0] m_word;
   logic        m_do = 1'b1;

   always @(posedge rom_cs) begin
      m_cnt = 0; m_do = 1'b1; m_addr = '0; m_op = '0; trans++;
   end

   always @(posedge rom_sk) if (rom_cs) begin
      m_cnt++;
      if (m_cnt <= 3) m_op = {m_op[1:0], rom_di};
      else if (m_cnt <= 3 + dev_aw) m_addr = {m_addr[6:0], rom_di};
      if (m_cnt == 3 + dev_aw) begin
         if (dev_aw == 6) m_addr = {2'b00, m_addr[5:0]};
         m_word = mem[m_addr];
         last_addr = m_addr;
         last_op = m_op;
         m_do = 1'b0;
         m_ptr = 15;
      end else if (m_cnt > 3 + dev_aw) begin
         m_do = (m_ptr >= 0) ? m_word[m_ptr] : 1'b0;
         m_ptr--;
      end
   end

   assign rom_do = rom_cs ? m_do : 1'b1;

   // ---------------- serial-side monitors ----------------
   int run = 0, runs = 0, bad_runs = 0, di_moves = 0;
   logic prev_di = 1'b0, prev_sk = 1'b0;
   always @(negedge clk) begin
      cycles++;
      if (rom_sk) run++;
      else if (run != 0) begin
         runs++;
         if (run != PH) bad_runs++;
         run = 0;
      end
      if (rom_sk && prev_sk && (rom_di != prev_di)) di_moves++;
      prev_di = rom_di;
      prev_sk = rom_sk;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] exp_mac(input logic [15:0] a, b, c);
      logic [17:0] s;
      s = 18'(a) + 18'(b) + 18'(c);
      if (s == 18'h0 || s == 18'h2FFFD) return 48'h0;
      return {a[7:0], a[15:8], b[7:0], b[15:8], c[7:0], c[15:8]};
   endfunction

   function automatic bit exp_bad(input logic [15:0] a, b, c);
      logic [17:0] s;
      s = 18'(a) + 18'(b) + 18'(c);
      return (s == 18'h0 || s == 18'h2FFFD);
   endfunction

   task automatic do_reset(input int aw);
      @(negedge clk);
      rst_n = 1'b0;
      dev_aw = aw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_done(output bit ok);
      int n = 0;
      ok = 0;
      while (n < 5000) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
         n++;
      end
   endtask

   task automatic run_op(input logic mode, input logic [7:0] idx, output bit ok);
      @(negedge clk);
      start = 1'b1; fetch_mac = mode; word_idx = idx;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8 busy after start", busy, 1);
      wait_done(ok);
      check(ok, "R9 done seen", ok, 1);
   endtask

   task automatic word_read(input logic [7:0] idx, input int exp_trans);
      bit ok;
      int t0;
      logic [7:0] ea;
      t0 = trans;
      ea = (dev_aw == 6) ? {2'b00, idx[5:0]} : idx;
      run_op(1'b0, idx, ok);
      check(rd_data == mem[ea], "R3 R10 read data", rd_data, mem[ea]);
      check(last_op == 3'b110, "R3 opcode", last_op, 3'b110);
      check(last_addr == ea, "R10 address sent", last_addr, ea);
      check(trans - t0 == exp_trans, "R2 frames per op", trans - t0, exp_trans);
      check(!busy && !rom_cs, "R8 idle at done", {busy, rom_cs}, 0);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", done, 0);
      check(rd_data == mem[ea], "R9 data held", rd_data, mem[ea]);
   endtask

   task automatic mac_fetch(input logic [15:0] a, b, c);
      bit ok;
      int t0;
      logic [47:0] prev_rd;
      mem[8'h0A] = a; mem[8'h0B] = b; mem[8'h0C] = c;
      t0 = trans;
      prev_rd = 48'(rd_data);
      run_op(1'b1, 8'h00, ok);
      check(mac_out == exp_mac(a, b, c), "R6 R7 station address", mac_out, exp_mac(a, b, c));
      check(mac_bad == exp_bad(a, b, c), "R7 bad flag", mac_bad, exp_bad(a, b, c));
      check(trans - t0 == 3, "R6 three word reads", trans - t0, 3);
      check(48'(rd_data) == prev_rd, "R9 rd_data kept in mac mode", rd_data, prev_rd);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      wait (cycles > 150000);
      if (!finished) begin
         finished = 1;
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      bit ok;
      logic [47:0] held_mac;
      void'($urandom(32'd2613));
      for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);

      repeat (2) @(negedge clk);
      check({busy, done, rom_cs, rom_sk, rom_di, addr8, mac_bad} == 7'b0,
            "R1 reset controls", {busy, done, rom_cs, rom_sk, rom_di, addr8, mac_bad}, 0);
      check(rd_data == 16'h0 && mac_out == 48'h0, "R1 reset data", {rd_data, mac_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // narrow device
      word_read(8'(($urandom % 64)), 2);
      check(addr8 == 1'b0, "R2 narrow detected", addr8, 0);
      for (int k = 0; k < 6; k++) word_read(8'($urandom), 1);
      word_read(8'h3F, 1);
      word_read(8'h00, 1);

      // start while busy is ignored
      begin
         int t0;
         t0 = trans;
         @(negedge clk);
         start = 1'b1; fetch_mac = 1'b0; word_idx = 8'h15;
         @(negedge clk);
         start = 1'b0;
         repeat (20) @(negedge clk);
         start = 1'b1; fetch_mac = 1'b1; word_idx = 8'h2A;
         @(negedge clk);
         start = 1'b0;
         wait_done(ok);
         check(rd_data == mem[8'h15], "R8 ignored start data", rd_data, mem[8'h15]);
         check(trans - t0 == 1, "R8 ignored start frames", trans - t0, 1);
      end

      // station address cases
      mac_fetch(16'($urandom), 16'($urandom), 16'($urandom));
      held_mac = mac_out;
      word_read(8'h05, 1);
      check(mac_out == held_mac, "R9 mac held over word read", mac_out, held_mac);
      mac_fetch(16'h0000, 16'h0000, 16'h0000);
      mac_fetch(16'hFFFF, 16'hFFFF, 16'hFFFF);
      mac_fetch(16'h0001, 16'hFFFF, 16'h0000);
      mac_fetch(16'h2301, 16'h6745, 16'hAB89);

      // wide device
      do_reset(8);
      check(addr8 == 1'b0 && rd_data == 16'h0, "R1 reset again", {addr8, rd_data}, 0);
      word_read(8'hC5, 2);
      check(addr8 == 1'b1, "R2 wide detected", addr8, 1);
      for (int k = 0; k < 6; k++) word_read(8'($urandom), 1);
      word_read(8'hFF, 1);
      mac_fetch(16'($urandom), 16'($urandom), 16'($urandom));

      check(runs > 0 && bad_runs == 0, "R5 high phase length", bad_runs, 0);
      check(di_moves == 0, "R4 di steady while sk high", di_moves, 0);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule